// File: doc/BRIEF.md
# Packed-share masked AND unit

The unit computes a masked AND on words in which every secret bit is held as a group of SHARES adjacent bits. A DATA_W-bit word is cut into DATA_W/SHARES groups. Each group carries one secret bit, and that bit is the XOR of the group. All groups are processed side by side, so one operation performs DATA_W/SHARES independent masked ANDs. The operands are never recombined inside the unit. Partial products between a group of one operand and rotated copies of the same group of the other are folded into an accumulator. Fresh random words, pulled from a valid/ready source, separate these partial products.

A rotator turns every group by the same amount, independently of the other groups. It uses a selection mask that is stepped once per iteration. A second mode re-randomises a single word. It draws one random word r and returns a XOR r XOR r, with the second r turned by one position inside each group. The caller pulses start_i while busy_o is low, waits for the one-cycle done_o, and then reads c_o.

Top module: `packed_mask_mul`

## Requirements
- R1: Bit numbering runs from the most significant bit, so group k occupies MSB-first positions k*SHARES to k*SHARES+SHARES-1. The XOR of a group is its secret bit. SHARES is a power of two from 2 to DATA_W.
- R2: In multiply mode (refresh_i low at start), each group of c_o XORs to the AND of the XORs of the matching groups of a_i and b_i.
- R3: In refresh mode (refresh_i high at start), each group of c_o XORs to the XOR of the matching group of a_i, and b_i has no effect on that result.
- R4: A random word is consumed in every cycle in which rnd_valid_i and rnd_ready_o are both high. A multiply consumes SHARES/4 words (one word when SHARES is 2), a refresh consumes one, and rnd_ready_o is high only while busy_o is high.
- R5: While rnd_ready_o is high and rnd_valid_i is low, the unit waits and keeps rnd_ready_o high, and the result is the same as with no stall.
- R6: With rnd_valid_i held high, done_o is first high a fixed number of rising edges after the edge that accepts start_i. For a multiply this is SHARES/2 plus the number of random words, so 6 for SHARES=8. For a refresh it is 2.
- R7: start_i is accepted only while busy_o is low. A start_i pulse during an operation is ignored and yields no extra done_o.
- R8: done_o is a single-cycle pulse. c_o changes only together with done_o and otherwise holds its value.
- R9: After reset, busy_o, done_o and rnd_ready_o are low and c_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (taken while not busy) |
| refresh_i | input | 1 | Operation select at start: 1 refresh, 0 multiply |
| a_i | input | DATA_W | First packed operand |
| b_i | input | DATA_W | Second packed operand (multiply only) |
| rnd_valid_i | input | 1 | Random word available |
| rnd_i | input | DATA_W | Random word |
| rnd_ready_o | output | 1 | Random word taken when valid is also high |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, c_o updated |
| c_o | output | DATA_W | Packed result |

## Verification
A wrongly stepped selection mask or a mis-sequenced iteration index corrupts some partial product or leaves a random word uncancelled. The next done_o then shows a group of c_o whose XOR disagrees with the expected secret bit, within one operation. A fault in the sequencer shows up in other ways. It can change the number of random handshakes between start and done_o. It can change the start-to-done latency, which is fixed when the source never stalls. It can also produce an extra or missing done_o pulse, and all of these are visible in the same operation.

// File: rtl/pmm_pkg.sv
`timescale 1ns/1ps
package pmm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAW,
    ST_ITER,
    ST_FIN
  } pmm_state_e;

endpackage

// File: rtl/pmm_mask_gen.sv
`timescale 1ns/1ps
// Per-group selection mask for the chunk rotator, stepped one position per iteration.
module pmm_mask_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SHARES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mask1_o
);

  logic [DATA_W-1:0] corr_base;
  logic [DATA_W-1:0] mask_q, corr_q;

  // one set bit at the least significant position of every group
  for (genvar p = 0; p < DATA_W; p++) begin : g_corr
    assign corr_base[p] = ((p % SHARES) == 0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      corr_q <= '0;
    end else if (load_i) begin
      mask_q <= ~corr_base;
      corr_q <= corr_base << 1;
    end else if (step_i) begin
      mask_q <= mask_q ^ corr_q;
      corr_q <= corr_q << 1;
    end
  end

  assign mask_o  = mask_q;
  assign mask1_o = ~corr_base;

endmodule

// File: rtl/pmm_chunk_rot.sv
`timescale 1ns/1ps
// Rotates every SHARES-bit group toward its MSB by amt_i; mask_i selects the kept upper part.
module pmm_chunk_rot #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SHARES = 8,
  parameter int unsigned AW     = 3
) (
  input  logic [DATA_W-1:0] w_i,
  input  logic [AW-1:0]     amt_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] w_o
);

  localparam int unsigned SW = AW + 1;

  logic [SW-1:0] shr;

  assign shr = SW'(SHARES) - {1'b0, amt_i};
  assign w_o = ((w_i << amt_i) & mask_i) | ((w_i >> shr) & ~mask_i);

endmodule

// File: rtl/pmm_ctrl.sv
`timescale 1ns/1ps
module pmm_ctrl
  import pmm_pkg::*;
#(
  parameter int unsigned HALF = 4,
  parameter int unsigned IW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          refresh_i,
  input  logic          rnd_valid_i,
  output logic          busy_o,
  output logic          rnd_ready_o,
  output logic          accept_o,
  output logic          take_o,
  output logic          first_o,
  output logic          iter_o,
  output logic          fin_o,
  output logic          refresh_o,
  output logic [IW-1:0] idx_o
);

  pmm_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d, idx_nxt;
  logic          first_q, first_d;
  logic          refresh_q, refresh_d;

  assign idx_nxt = idx_q + IW'(1);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    first_d   = first_q;
    refresh_d = refresh_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_DRAW;
        idx_d     = IW'(1);
        first_d   = 1'b1;
        refresh_d = refresh_i;
      end
      ST_DRAW: if (rnd_valid_i) begin
        first_d = 1'b0;
        state_d = (refresh_q || (HALF == 1)) ? ST_FIN : ST_ITER;
      end
      ST_ITER: begin
        idx_d = idx_nxt;
        if (idx_q == IW'(HALF - 1)) state_d = ST_FIN;
        else if (!idx_nxt[0])       state_d = ST_DRAW;
        else                        state_d = ST_ITER;
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      first_q   <= 1'b0;
      refresh_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      first_q   <= first_d;
      refresh_q <= refresh_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign rnd_ready_o = (state_q == ST_DRAW);
  assign accept_o    = (state_q == ST_IDLE) && start_i;
  assign take_o      = (state_q == ST_DRAW) && rnd_valid_i;
  assign first_o     = first_q;
  assign iter_o      = (state_q == ST_ITER);
  assign fin_o       = (state_q == ST_FIN);
  assign refresh_o   = refresh_q;
  assign idx_o       = idx_q;

endmodule

// File: rtl/packed_mask_mul.sv
`timescale 1ns/1ps
module packed_mask_mul #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SHARES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              refresh_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              rnd_valid_i,
  input  logic [DATA_W-1:0] rnd_i,
  output logic              rnd_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] c_o
);

  localparam int unsigned HALF = SHARES / 2;
  localparam int unsigned IW   = (HALF < 2) ? 1 : $clog2(HALF + 1);

  logic              accept, take, first, iter, fin, refresh;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] mask, mask1;
  logic [DATA_W-1:0] a_q, b_q, r_q, y_q, c_q;
  logic              done_q;
  logic [DATA_W-1:0] rot_a, rot_b, rot_r1, r_term, c_mul, c_ref;

  pmm_ctrl #(.HALF(HALF), .IW(IW)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .refresh_i   (refresh_i),
    .rnd_valid_i (rnd_valid_i),
    .busy_o      (busy_o),
    .rnd_ready_o (rnd_ready_o),
    .accept_o    (accept),
    .take_o      (take),
    .first_o     (first),
    .iter_o      (iter),
    .fin_o       (fin),
    .refresh_o   (refresh),
    .idx_o       (idx)
  );

  pmm_mask_gen #(.DATA_W(DATA_W), .SHARES(SHARES)) mask_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .step_i  (iter),
    .mask_o  (mask),
    .mask1_o (mask1)
  );

  pmm_chunk_rot #(.DATA_W(DATA_W), .SHARES(SHARES), .AW(IW)) rot_b_i (
    .w_i (b_q), .amt_i (idx), .mask_i (mask), .w_o (rot_b)
  );

  pmm_chunk_rot #(.DATA_W(DATA_W), .SHARES(SHARES), .AW(IW)) rot_a_i (
    .w_i (a_q), .amt_i (idx), .mask_i (mask), .w_o (rot_a)
  );

  pmm_chunk_rot #(.DATA_W(DATA_W), .SHARES(SHARES), .AW(IW)) rot_r_i (
    .w_i (r_q), .amt_i (IW'(1)), .mask_i (mask1), .w_o (rot_r1)
  );

  // odd iterations fold the turned random word, even ones the fresh word
  assign r_term = idx[0] ? rot_r1 : r_q;
  assign c_mul  = y_q ^ (a_q & rot_b) ^ ((HALF == 1) ? rot_r1 : '0);
  assign c_ref  = a_q ^ r_q ^ rot_r1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      r_q    <= '0;
      y_q    <= '0;
      c_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (accept) begin
        a_q <= a_i;
        b_q <= b_i;
      end
      if (take) begin
        r_q <= rnd_i;
        if (first && !refresh) y_q <= (a_q & b_q) ^ rnd_i;
      end
      if (iter) y_q <= y_q ^ (a_q & rot_b) ^ (rot_a & b_q) ^ r_term;
      if (fin)  c_q <= refresh ? c_ref : c_mul;
    end
  end

  assign done_o = done_q;
  assign c_o    = c_q;

endmodule

// File: rtl/pmm_checker.sv
`timescale 1ns/1ps
module pmm_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SHARES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              refresh_i,
  input logic              rnd_valid_i,
  input logic              rnd_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] c_o
);

  localparam int unsigned MUL_DRAWS = (SHARES == 2) ? 1 : SHARES / 4;

  logic [7:0] draw_cnt;
  logic       op_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      draw_cnt <= '0;
      op_ref   <= 1'b0;
    end else if (!busy_o && start_i) begin
      draw_cnt <= '0;
      op_ref   <= refresh_i;
    end else if (rnd_valid_i && rnd_ready_o) begin
      draw_cnt <= draw_cnt + 8'd1;
    end
  end

  // R4
  draw_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (draw_cnt == (op_ref ? 8'd1 : 8'(MUL_DRAWS))));

  // R4
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_ready_o |-> busy_o);

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_ready_o && !rnd_valid_i) |=> rnd_ready_o);

  // R7
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(c_o) |-> done_o);

endmodule

bind packed_mask_mul pmm_checker #(.DATA_W(DATA_W), .SHARES(SHARES)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .refresh_i   (refresh_i),
  .rnd_valid_i (rnd_valid_i),
  .rnd_ready_o (rnd_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .c_o         (c_o)
);

// File: tb/packed_mask_mul_tb_top.sv
`timescale 1ns/1ps
module packed_mask_mul_tb_top;

  localparam int W     = 32;
  localparam int D     = 8;
  localparam int CH    = W / D;
  localparam int DRAWS = (D == 2) ? 1 : D / 4;

  typedef struct {
    bit          rf;
    bit          stall;
    logic [CH-1:0] par;
    int          draws;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         refresh_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         rnd_valid_i = 1'b0;
  logic [W-1:0] rnd_i = '0;
  logic         rnd_ready_o, busy_o, done_o;
  logic [W-1:0] c_o;

  int   checks = 0;
  int   errors = 0;
  int   n_ops = 0;
  int   n_done = 0;
  int   hs = 0;
  bit   stall_mode = 1'b0;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  packed_mask_mul #(.DATA_W(W), .SHARES(D)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .refresh_i   (refresh_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .rnd_valid_i (rnd_valid_i),
    .rnd_i       (rnd_i),
    .rnd_ready_o (rnd_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .c_o         (c_o)
  );

  // R1: group k is MSB-first bits k*D..k*D+D-1, secret = XOR of the group
  function automatic logic [CH-1:0] grp_par(logic [W-1:0] w);
    logic [CH-1:0] p;
    for (int k = 0; k < CH; k++) p[k] = ^w[W-1-k*D -: D];
    return p;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // random source, updated away from the sampling edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      rnd_i       = $urandom;
      rnd_valid_i = rst_ni && (stall_mode ? (($urandom % 3) != 0) : 1'b1);
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (rnd_valid_i && rnd_ready_o) hs++;
        if (done_o) begin
          n_done++;
          if (sb_q.size() == 0) begin
            check(1'b0, "R7 unexpected done", 32'(n_done), 32'(n_ops));
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.rf)
              check(grp_par(c_o) == e.par, e.stall ? "R5 R3 refresh parity" : "R3 refresh parity",
                    W'(grp_par(c_o)), W'(e.par));
            else
              check(grp_par(c_o) == e.par, e.stall ? "R5 R2 multiply parity" : "R2 multiply parity",
                    W'(grp_par(c_o)), W'(e.par));
            check(hs == e.draws, "R4 random words per operation", W'(hs), W'(e.draws));
          end
          hs = 0;
        end
      end
    end
  end

  task automatic run_op(bit rf, logic [W-1:0] a, logic [W-1:0] b, bit chk_lat, bit poke);
    exp_t e;
    int   n;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    e.rf    = rf;
    e.stall = stall_mode;
    e.par   = rf ? grp_par(a) : (grp_par(a) & grp_par(b));
    e.draws = rf ? 1 : DRAWS;
    sb_q.push_back(e);
    n_ops++;
    start_i   = 1'b1;
    refresh_i = rf;
    a_i       = a;
    b_i       = b;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = poke;
    if (poke) begin
      refresh_i = ~rf;
      a_i       = ~a;
      b_i       = ~b;
    end
    n = 0;
    while (!done_o) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    if (chk_lat)
      check(n == (rf ? 2 : DRAWS + D / 2), "R6 latency", W'(n), W'(rf ? 2 : DRAWS + D / 2));
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9
    check(!busy_o, "R9 busy after reset", W'(busy_o), '0);
    check(!done_o, "R9 done after reset", W'(done_o), '0);
    check(!rnd_ready_o, "R9 ready after reset", W'(rnd_ready_o), '0);
    check(c_o == '0, "R9 result after reset", c_o, '0);

    // R2 fixed patterns, R6 latency
    run_op(1'b0, '0, '0, 1'b1, 1'b0);
    run_op(1'b0, '1, '1, 1'b1, 1'b0);
    run_op(1'b0, '1, '0, 1'b1, 1'b0);
    run_op(1'b0, 32'h8000_0001, 32'h0100_0080, 1'b1, 1'b0);
    run_op(1'b0, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b0);
    for (int k = 0; k < 40; k++) run_op(1'b0, $urandom, $urandom, 1'b1, 1'b0);

    // R3 refresh, b varied
    run_op(1'b1, 32'h0123_4567, '1, 1'b1, 1'b0);
    run_op(1'b1, 32'h0123_4567, '0, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) run_op(1'b1, $urandom, $urandom, 1'b1, 1'b0);

    // R7 start while busy is ignored
    run_op(1'b0, 32'hF0F0_0F0F, 32'hFF00_00FF, 1'b1, 1'b1);
    run_op(1'b1, 32'h1357_9BDF, 32'h0, 1'b1, 1'b1);

    // R8 result held, done one cycle
    held = c_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      check(!done_o, "R8 done single pulse", W'(done_o), '0);
      check(c_o == held, "R8 result held", c_o, held);
    end

    // R5 stalled random source
    stall_mode = 1'b1;
    for (int k = 0; k < 30; k++) run_op(k[0], $urandom, $urandom, 1'b0, 1'b0);
    stall_mode = 1'b0;

    repeat (10) @(negedge clk_i);
    check(sb_q.size() == 0, "R7 pending results", W'(sb_q.size()), '0);
    check(n_done == n_ops, "R7 done count", W'(n_done), W'(n_ops));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_ops);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule